// File: doc/BRIEF.md
# Coefficient Run-Length Tokenizer

This block turns one 8x8 block of quantized transform coefficients into a stream of token records for an entropy coder. The 64 coefficients come in already in zig-zag order, one signed value per accepted input beat. Position 0 is the DC term and positions 1 to 63 are the AC terms. Each output record is a 5-bit token, a 10-bit extra-bits field (right-aligned) and a 4-bit extra-bits length. A flag marks the final record of the block.

Each token stands for one or more coefficient positions, and the tokens of a block always add up to 64 positions. A zero run that is followed by a nonzero coefficient becomes a run token. Zeros that reach the end of the block are closed by a single end-of-block token, never by a run token. Nonzero values are split into sign and magnitude classes. Both sides use valid/ready handshakes. Input ready drops whenever a record is stalled, so no coefficient is lost. Blocks follow one another with no gap.

Top module: `coef_tokenizer`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: A coefficient of +1 gives token 9 and a coefficient of -1 gives token 10. Both have extra length 0 and cover one position.
- R3: A coefficient whose magnitude m lies in 2..1023 has bit length L in 2..10. It gives token 12+L with extra length L. Extra bit L-1 holds the sign (1 means negative) and bits L-2..0 hold the low bits of m. Token 22 covers magnitudes 512..1023 with 10 extra bits.
- R4: A magnitude above 1023 is saturated to 1023 with its sign kept. It is then coded as token 22.
- R5: A run of n zeros (1 ≤ n ≤ 63) followed by a nonzero coefficient gives token 8 with extra length 6 and extra value n. This record comes right before the value token of that nonzero coefficient.
- R6: If position 63 is zero, the block ends with exactly one token 0, with extra length 0 and the last flag set. That token covers every position from the start of the trailing zero run to 63. Token 8 never closes a block.
- R7: A block of all zeros gives exactly one record, token 0 with the last flag set.
- R8: The tokens of each block cover exactly 64 positions, and expanding them gives back the (saturated) input. The last flag is set on the final record of the block and on no other record.
- R9: While outValid is 1 and outReady is 0, the output record stays unchanged. Every coefficient is accepted exactly once, so output backpressure loses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Coefficient on inCoef is valid |
| inReady | output | 1 | Block accepts a coefficient this cycle |
| inCoef | input | COEF_W (16) | Signed coefficient in zig-zag order |
| outValid | output | 1 | Output record is valid |
| outReady | input | 1 | Downstream accepts the record |
| outToken | output | 5 | Token code |
| outExtra | output | 10 | Extra bits, right-aligned |
| outExtraLen | output | 4 | Number of meaningful extra bits |
| outLast | output | 1 | Final record of the block |

## Verification
The bench drives directed blocks of several kinds:
- Sparse blocks with a long interior run tell the run token apart from the end-of-block token.
- A block with an isolated final nonzero at position 63 reaches the widest run length.
- A block whose only trailing zero is position 63 tests the single-position end-of-block case.
- All-zero blocks and blocks with mixed magnitudes, including out-of-range values, separate the sign/magnitude classes and the saturation path from the unit tokens.

Every block is expanded back into 64 coefficients and compared with the input. A mixed block is also sent under a pseudo-random outReady pattern, which shows whether records hold steady and whether coefficients are dropped or duplicated when the output stalls.

// File: rtl/tok_pkg.sv
package tok_pkg;
  localparam int TOK_W     = 5;
  localparam int EXT_W     = 10;
  localparam int LEN_W     = 4;
  localparam int MAG_BITS  = 10;
  localparam int ZRUN_LEN  = 6;

  localparam logic [TOK_W-1:0] TOK_EOB  = 5'd0;
  localparam logic [TOK_W-1:0] TOK_ZRUN = 5'd8;
  localparam logic [TOK_W-1:0] TOK_POS1 = 5'd9;
  localparam logic [TOK_W-1:0] TOK_NEG1 = 5'd10;
  localparam int               TOK_MAG_BASE = 12;

  typedef struct packed {
    logic [TOK_W-1:0] token;
    logic [EXT_W-1:0] extra;
    logic [LEN_W-1:0] extraLen;
    logic             last;
  } tokRec_t;

  typedef enum logic [1:0] {SEL_PEND, SEL_VALUE, SEL_RUN, SEL_EOB} outSel_e;

  typedef struct packed {
    logic             outLoad;
    outSel_e          outSel;
    logic             pendLoad;
    logic             lastTag;
    logic [EXT_W-1:0] runLen;
  } strobes_t;
endpackage

// File: rtl/tok_value_map.sv
module tok_value_map
  import tok_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic [COEF_W-1:0] coef,
  output logic              isZero,
  output logic [TOK_W-1:0]  valToken,
  output logic [EXT_W-1:0]  valExtra,
  output logic [LEN_W-1:0]  valLen
);
  localparam int MAG_LIMIT = (2 ** MAG_BITS) - 1;
  localparam int AW = COEF_W + 1;

  logic          neg;
  logic [AW-1:0] signExt;
  logic [AW-1:0] absVal;
  logic [MAG_BITS-1:0] mag;
  logic [LEN_W-1:0]    bitLen;

  always_comb begin
    neg     = coef[COEF_W-1];
    signExt = {coef[COEF_W-1], coef};
    absVal  = neg ? (~signExt + AW'(1)) : signExt;
    mag     = (absVal > AW'(MAG_LIMIT)) ? MAG_BITS'(MAG_LIMIT) : absVal[MAG_BITS-1:0];
    isZero  = (coef == '0);

    bitLen = '0;
    for (int b = 0; b < MAG_BITS; b++) begin
      if (mag[b]) bitLen = LEN_W'(b + 1);
    end

    valExtra = '0;
    if (isZero) begin
      valToken = TOK_EOB;
      valLen   = '0;
    end else if (mag == MAG_BITS'(1)) begin
      valToken = neg ? TOK_NEG1 : TOK_POS1;
      valLen   = '0;
    end else begin
      valToken = TOK_W'(TOK_MAG_BASE) + TOK_W'(bitLen);
      valLen   = bitLen;
      for (int b = 0; b < MAG_BITS; b++) begin
        if (b + 1 < int'(bitLen))       valExtra[b] = mag[b];
        else if (b + 1 == int'(bitLen)) valExtra[b] = neg;
      end
    end
  end
endmodule

// File: rtl/tok_datapath.sv
module tok_datapath
  import tok_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COEF_W-1:0] coef,
  input  strobes_t          st,
  output logic              coefZero,
  output tokRec_t           outRec
);
  logic [TOK_W-1:0] valToken;
  logic [EXT_W-1:0] valExtra;
  logic [LEN_W-1:0] valLen;
  tokRec_t          pendRec;

  tok_value_map #(.COEF_W(COEF_W)) u_map (
    .coef     (coef),
    .isZero   (coefZero),
    .valToken (valToken),
    .valExtra (valExtra),
    .valLen   (valLen)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendRec <= '0;
    end else if (st.pendLoad) begin
      pendRec <= '{token: valToken, extra: valExtra, extraLen: valLen, last: st.lastTag};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outRec <= '0;
    end else if (st.outLoad) begin
      case (st.outSel)
        SEL_PEND:  outRec <= pendRec;
        SEL_VALUE: outRec <= '{token: valToken, extra: valExtra, extraLen: valLen,
                               last: st.lastTag};
        SEL_RUN:   outRec <= '{token: TOK_ZRUN, extra: st.runLen,
                               extraLen: LEN_W'(ZRUN_LEN), last: 1'b0};
        default:   outRec <= '{token: TOK_EOB, extra: '0, extraLen: '0, last: 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/tok_control.sv
module tok_control
  import tok_pkg::*;
#(
  parameter int BLOCK_LEN = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     coefZero,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output strobes_t st
);
  localparam int IDX_W = $clog2(BLOCK_LEN);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] runCnt;
  logic             pendValid;
  logic             outFree;
  logic             accept;
  logic             lastIdx;

  always_comb begin
    outFree = !outValid || outReady;
    inReady = !pendValid && outFree;
    accept  = inValid && inReady;
    lastIdx = (idx == IDX_W'(BLOCK_LEN - 1));

    st = '0;
    if (pendValid && outFree) begin
      st.outLoad = 1'b1;
      st.outSel  = SEL_PEND;
    end else if (accept) begin
      if (coefZero) begin
        if (lastIdx) begin
          st.outLoad = 1'b1;
          st.outSel  = SEL_EOB;
        end
      end else if (runCnt != '0) begin
        st.outLoad  = 1'b1;
        st.outSel   = SEL_RUN;
        st.runLen   = EXT_W'(runCnt);
        st.pendLoad = 1'b1;
        st.lastTag  = lastIdx;
      end else begin
        st.outLoad = 1'b1;
        st.outSel  = SEL_VALUE;
        st.lastTag = lastIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx       <= '0;
      runCnt    <= '0;
      outValid  <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      if (st.outLoad)   outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;

      if (st.pendLoad) pendValid <= 1'b1;
      else if (st.outLoad && st.outSel == SEL_PEND) pendValid <= 1'b0;

      if (accept) begin
        idx    <= lastIdx ? '0 : idx + IDX_W'(1);
        runCnt <= (coefZero && !lastIdx) ? runCnt + IDX_W'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/coef_tokenizer.sv
module coef_tokenizer
  import tok_pkg::*;
#(
  parameter int COEF_W    = 16,
  parameter int BLOCK_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [COEF_W-1:0] inCoef,
  output logic              outValid,
  input  logic              outReady,
  output logic [4:0]        outToken,
  output logic [9:0]        outExtra,
  output logic [3:0]        outExtraLen,
  output logic              outLast
);
  strobes_t st;
  logic     coefZero;
  tokRec_t  outRec;

  tok_control #(.BLOCK_LEN(BLOCK_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .coefZero (coefZero),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .st       (st)
  );

  tok_datapath #(.COEF_W(COEF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .coef     (inCoef),
    .st       (st),
    .coefZero (coefZero),
    .outRec   (outRec)
  );

  assign outToken    = outRec.token;
  assign outExtra    = outRec.extra;
  assign outExtraLen = outRec.extraLen;
  assign outLast     = outRec.last;
endmodule

// File: rtl/coef_tokenizer_checker.sv
module coef_tokenizer_checker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [4:0] outToken,
  input logic [9:0] outExtra,
  input logic [3:0] outExtraLen,
  input logic       outLast
);
  p_unit_noextra_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outToken == 5'd9 || outToken == 5'd10) |-> outExtraLen == 4'd0);

  p_value_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outToken >= 5'd14 && outToken <= 5'd22 |->
      ({1'b0, outExtraLen} == outToken - 5'd12));

  p_run_field_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outToken == 5'd8 |->
      outExtraLen == 4'd6 && outExtra != 10'd0 && outExtra < 10'd64 && !outLast);

  p_eob_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outToken == 5'd0 |-> outLast && outExtraLen == 4'd0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outToken) && $stable(outExtra)
      && $stable(outExtraLen) && $stable(outLast));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  p_no_input_unused_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inReady |-> outValid);
endmodule

bind coef_tokenizer coef_tokenizer_checker u_chk (.*);

// File: tb/coef_tokenizer_bench.sv
module coef_tokenizer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inCoef = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [4:0]  outToken;
  logic [9:0]  outExtra;
  logic [3:0]  outExtraLen;
  logic        outLast;

  coef_tokenizer u_coef_tokenizer (.*);

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int qTok[$], qExt[$], qLen[$], qLast[$];
  int nLast = 0;
  int nStall = 0;
  bit bpMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic prevStall = 1'b0;
  logic [19:0] prevRec = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady <= bpMode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check({outValid, outToken, outExtra, outExtraLen, outLast} == {1'b1, prevRec},
              "R9 record held under stall", int'({outToken, outExtra}), int'(prevRec[19:5]));
      prevStall = outValid && !outReady;
      prevRec   = {outToken, outExtra, outExtraLen, outLast};
      if (prevStall) nStall++;
      if (outValid && outReady) begin
        qTok.push_back(int'(outToken));
        qExt.push_back(int'(outExtra));
        qLen.push_back(int'(outExtraLen));
        qLast.push_back(int'(outLast));
        if (outLast) nLast++;
      end
    end
  end

  function automatic int sat(input int v);
    if (v > 1023) return 1023;
    if (v < -1023) return -1023;
    return v;
  endfunction

  task automatic sendBlock(input int c[64]);
    for (int i = 0; i < 64; i++) begin
      inCoef  = 16'(c[i]);
      inValid = 1'b1;
      forever begin
        @(negedge clk);
        if (inReady) break;
      end
      @(posedge clk);
      #1;
    end
    inValid = 1'b0;
  endtask

  task automatic runBlock(input string name, input int c[64]);
    int target;
    int pos;
    int dec[64];
    bit lastOk;
    bit bad;
    int firstBad;
    qTok.delete(); qExt.delete(); qLen.delete(); qLast.delete();
    target = nLast + 1;
    sendBlock(c);
    for (int w = 0; w < 2000 && nLast < target; w++) @(posedge clk);
    #1;
    check(nLast == target, {"R8 block completes: ", name}, nLast, target);
    pos = 0; lastOk = 1'b1; bad = 1'b0;
    for (int k = 0; k < 64; k++) dec[k] = 9999;
    for (int k = 0; k < qTok.size(); k++) begin
      if (qLast[k] != ((k == qTok.size() - 1) ? 1 : 0)) lastOk = 1'b0;
      case (qTok[k])
        0:  while (pos < 64) begin dec[pos] = 0; pos++; end
        8:  for (int r = 0; r < qExt[k]; r++) begin if (pos < 64) dec[pos] = 0; pos++; end
        9:  begin if (pos < 64) dec[pos] = 1; pos++; end
        10: begin if (pos < 64) dec[pos] = -1; pos++; end
        default: begin
          if (qTok[k] >= 14 && qTok[k] <= 22) begin
            int len = qTok[k] - 12;
            int m = (1 << (len - 1)) | (qExt[k] & ((1 << (len - 1)) - 1));
            if (pos < 64) dec[pos] = ((qExt[k] >> (len - 1)) & 1) ? -m : m;
            pos++;
          end else bad = 1'b1;
        end
      endcase
    end
    check(!bad, {"R8 known tokens: ", name}, int'(bad), 0);
    check(pos == 64, {"R8 coverage is 64: ", name}, pos, 64);
    check(lastOk, {"R8 last only on final record: ", name}, int'(lastOk), 1);
    firstBad = -1;
    for (int k = 63; k >= 0; k--) if (dec[k] != sat(c[k])) firstBad = k;
    check(firstBad < 0, {"R8 round trip: ", name},
          (firstBad < 0) ? 0 : dec[firstBad], (firstBad < 0) ? 0 : sat(c[firstBad]));
    if (sat(c[63]) == 0 && qTok.size() > 0)
      check(qTok[qTok.size() - 1] == 0, {"R6 end-of-block closes: ", name},
            qTok[qTok.size() - 1], 0);
  endtask

  task automatic expectTok(input int k, input int tok, input int ext, input int len,
                           input int last, input string req);
    if (k >= qTok.size()) begin
      check(1'b0, {req, " record missing"}, qTok.size(), k + 1);
    end else begin
      check(qTok[k] == tok, {req, " token"}, qTok[k], tok);
      check(qExt[k] == ext && qLen[k] == len, {req, " extra/len"},
            qExt[k] * 16 + qLen[k], ext * 16 + len);
      check(qLast[k] == last, {req, " last"}, qLast[k], last);
    end
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
  endtask

  task automatic testSparseEnds();
    int c[64] = '{default: 0};
    c[0] = 1; c[63] = 1;
    runBlock("sparse ends", c);
    check(qTok.size() == 3, "R5 record count sparse ends", qTok.size(), 3);
    expectTok(0, 9, 0, 0, 0, "R2 DC +1");
    expectTok(1, 8, 62, 6, 0, "R5 run of 62");
    expectTok(2, 9, 0, 0, 1, "R2 AC63 +1");
  endtask

  task automatic testTwoUnits();
    int c[64] = '{default: 0};
    c[0] = 1; c[1] = 1; c[63] = 1;
    runBlock("two units", c);
    check(qTok.size() == 4, "R5 record count two units", qTok.size(), 4);
    expectTok(0, 9, 0, 0, 0, "R2 pos0");
    expectTok(1, 9, 0, 0, 0, "R2 pos1");
    expectTok(2, 8, 61, 6, 0, "R5 run of 61");
    expectTok(3, 9, 0, 0, 1, "R2 pos63");
  endtask

  task automatic testTrailing();
    int c[64] = '{default: 0};
    c[0] = 5; c[1] = -3; c[2] = -1;
    runBlock("trailing zeros", c);
    check(qTok.size() == 4, "R6 record count trailing", qTok.size(), 4);
    expectTok(0, 15, 1, 3, 0, "R3 value 5");
    expectTok(1, 14, 3, 2, 0, "R3 value -3");
    expectTok(2, 10, 0, 0, 0, "R2 value -1");
    expectTok(3, 0, 0, 0, 1, "R6 end-of-block");
  endtask

  task automatic testAllZero();
    int c[64] = '{default: 0};
    runBlock("all zero", c);
    check(qTok.size() == 1, "R7 single record", qTok.size(), 1);
    expectTok(0, 0, 0, 0, 1, "R7 end-of-block");
  endtask

  task automatic testLarge();
    int c[64] = '{default: 0};
    c[0] = -700; c[1] = 2000; c[2] = -32768; c[3] = 2; c[4] = 1023;
    runBlock("large magnitudes", c);
    expectTok(0, 22, 700, 10, 0, "R3 value -700");
    expectTok(1, 22, 511, 10, 0, "R4 saturate 2000");
    expectTok(2, 22, 1023, 10, 0, "R4 saturate -32768");
    expectTok(3, 14, 0, 2, 0, "R3 value 2");
    expectTok(4, 22, 511, 10, 0, "R3 value 1023");
    expectTok(5, 0, 0, 0, 1, "R6 end-of-block large");
  endtask

  task automatic testLongRun();
    int c[64] = '{default: 0};
    c[63] = -2;
    runBlock("run of 63", c);
    check(qTok.size() == 2, "R5 record count long run", qTok.size(), 2);
    expectTok(0, 8, 63, 6, 0, "R5 run of 63");
    expectTok(1, 14, 2, 2, 1, "R3 value -2 at 63");
  endtask

  task automatic testLastZero();
    int c[64];
    for (int i = 0; i < 64; i++) c[i] = (i == 63) ? 0 : 1;
    runBlock("only pos63 zero", c);
    check(qTok.size() == 64, "R6 record count single trailing zero", qTok.size(), 64);
    expectTok(63, 0, 0, 0, 1, "R6 end-of-block at 63");
  endtask

  task automatic testBackpressure();
    int c[64];
    int stallsBefore = nStall;
    for (int i = 0; i < 64; i++)
      c[i] = (i % 5 == 0 && i < 60) ? ((i * 37) % 300 - 150) : ((i % 7 == 3) ? -1 : 0);
    bpMode = 1'b1;
    runBlock("backpressure mixed", c);
    runBlock("backpressure repeat", c);
    bpMode = 1'b0;
    check(nStall > stallsBefore, "R9 stalls exercised", nStall - stallsBefore, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testReset();
    @(posedge clk); #1;
    testSparseEnds();
    testTwoUnits();
    testTrailing();
    testAllZero();
    testLarge();
    testLongRun();
    testLastZero();
    testBackpressure();
    testAllZero();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule